// File: doc/BRIEF.md
# Disk sector read streamer

This block plays the read side of a cartridge disk drive whose sector images sit in external SDRAM. A read request gives a cylinder, a head and a sector number. The block builds a word address from those fields by placing each sector in a fixed 512-word slot. The unused words at the end of each slot are never read. The block then fetches the sector's 321 sixteen-bit words in ascending address order through a single-outstanding request/acknowledge port.

Each word is turned into a serial pulse stream for a legacy disk controller. The stream has one bit cell per bit, most-significant bit first. Every cell carries a clock pulse on one output, and a cell for a 1 bit also carries a data pulse on a second output. The next word is fetched while the current one is still being shifted out, so the cells follow one another without gaps. A one-cycle done pulse marks the end of the sector. Read requests that arrive while a sector is in progress are dropped.

Top module: `sector_read_streamer`

## Requirements
- R1: A synchronous reset, applied at any time, leaves both pulse outputs, the memory request, busy and done low, and no further memory request is issued until a new read is started.
- R2: The first word address of a sector is sector×512 + head×2048 + cylinder×4096 (sector in address bits [10:9], head in bit 11, cylinder from bit 12 up). Cylinder 0, head 0, sector 0 starts at 0. Cylinder 1, head 1, sector 1 starts at 0x1A00.
- R3: A sector read issues exactly 321 memory reads at consecutive ascending addresses from the base to base+320. For cylinder 1, head 1, sector 1 this means 0x1A00 through 0x1B40.
- R4: Once rd_req is raised, it stays high with rd_addr unchanged until rd_ack is seen high at a clock edge. rd_data is taken in that same cycle. Only one read is outstanding at a time.
- R5: Every bit cell is CELL_CYC cycles long. clk_pulse is high for its first CLK_W cycles and low for the rest of the cell.
- R6: data_pulse is high in cycles DAT_OFF to DAT_OFF+DAT_W-1 of a cell exactly when that cell's bit is 1. It is never high together with clk_pulse. Bits go out most-significant first.
- R7: Within a sector, each bit cell starts exactly CELL_CYC cycles after the previous one whenever each memory read is answered within one word time.
- R8: A read request raised while busy is high has no effect on the addresses read or on the words sent.
- R9: done is high for exactly one cycle: the cycle right after the final cycle of the last bit cell of word 321. busy is low in that cycle.
- R10: The 16 bits sent for the k-th word of a sector equal the data that memory returned for address base+k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Read request; accepted only when idle |
| cyl_in | input | CYL_W | Cylinder number of the request |
| head_in | input | HEAD_W | Head number of the request |
| sect_in | input | SEC_W | Sector number of the request |
| busy | output | 1 | Sector read in progress |
| done | output | 1 | One-cycle end-of-sector pulse |
| rd_req | output | 1 | Memory read request, held until acknowledged |
| rd_addr | output | ADDR_W | Memory word address |
| rd_ack | input | 1 | Memory acknowledge; rd_data valid in this cycle |
| rd_data | input | WORD_W | Memory read data |
| clk_pulse | output | 1 | Bit-cell clock pulse |
| data_pulse | output | 1 | Data pulse for a 1 bit |

## Verification
A wrong base register or a broken word counter shows up on the first or the next rd_addr. The wrong value is visible as soon as the request rises, long before any pulse is compared. A shift or bit-count fault puts a wrong 16-bit word on the pulse outputs within one word time, which is 16 cells. A fault in the cell counter shows up as a cell spaced differently from CELL_CYC within the next cell, or as done landing off the cycle after the last cell. Requests fired in the middle of a sector show whether the locked base can be disturbed: any change would bend the address sequence on the very next read.

// File: rtl/sread_pkg.sv
package sread_pkg;

   typedef enum logic {
      FETCH_IDLE = 1'b0,
      FETCH_RUN  = 1'b1
   } fetch_state_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sread_addr_map.sv
module sread_addr_map #(
   parameter int unsigned CYL_W     = 8,
   parameter int unsigned HEAD_W    = 1,
   parameter int unsigned SEC_W     = 2,
   parameter int unsigned SLOT_LOG2 = 9,
   parameter int unsigned ADDR_W    = 24
) (
   input  logic [CYL_W-1:0]  cyl,
   input  logic [HEAD_W-1:0] head,
   input  logic [SEC_W-1:0]  sect,
   output logic [ADDR_W-1:0] base
);
   localparam int unsigned MAP_W = CYL_W + HEAD_W + SEC_W + SLOT_LOG2;

   generate
      if (MAP_W > ADDR_W) begin : g_bad_width
         $error("sread_addr_map: slot fields exceed ADDR_W");
      end
      if (MAP_W < ADDR_W) begin : g_padded
         assign base = {{(ADDR_W - MAP_W){1'b0}}, cyl, head, sect, {SLOT_LOG2{1'b0}}};
      end else begin : g_exact
         assign base = {cyl, head, sect, {SLOT_LOG2{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/sread_fetch.sv
module sread_fetch
   import sread_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned WORDS  = 321
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_in,
   input  logic              take,
   input  logic              finish,
   input  logic              rd_ack,
   input  logic [WORD_W-1:0] rd_data,
   output logic              busy,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              buf_valid,
   output logic [WORD_W-1:0] buf_data
);
   localparam int unsigned CNT_W = cnt_width(WORDS + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORDS);

   fetch_state_e      state;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  issued;

   assign busy = (state == FETCH_RUN);

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= FETCH_IDLE;
         base_q    <= '0;
         issued    <= '0;
         rd_req    <= 1'b0;
         rd_addr   <= '0;
         buf_valid <= 1'b0;
         buf_data  <= '0;
      end else begin
         case (state)
            FETCH_IDLE: begin
               if (start) begin
                  state     <= FETCH_RUN;
                  base_q    <= base_in;
                  issued    <= '0;
                  buf_valid <= 1'b0;
               end
            end
            FETCH_RUN: begin
               if (rd_req && rd_ack) begin
                  rd_req    <= 1'b0;
                  buf_data  <= rd_data;
                  buf_valid <= 1'b1;
                  issued    <= issued + 1'b1;
               end else if (!rd_req && !buf_valid && issued != LAST_CNT) begin
                  rd_req  <= 1'b1;
                  rd_addr <= base_q + ADDR_W'(issued);
               end
               if (take) begin
                  buf_valid <= 1'b0;
               end
               if (finish) begin
                  state <= FETCH_IDLE;
               end
            end
            default: state <= FETCH_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R4

   AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (rst)
      rd_req |-> ((rd_addr >= base_q) && ((rd_addr - base_q) < ADDR_W'(WORDS)))); // R3

   AST_BASE_LOCK: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(base_q)); // R8

   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !rd_req); // R1

endmodule

// File: rtl/sread_serial.sv
module sread_serial
   import sread_pkg::*;
#(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned WORDS    = 321,
   parameter int unsigned CELL_CYC = 8,
   parameter int unsigned CLK_W    = 2,
   parameter int unsigned DAT_OFF  = 4,
   parameter int unsigned DAT_W    = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              busy,
   input  logic              buf_valid,
   input  logic [WORD_W-1:0] buf_data,
   output logic              take,
   output logic              finish,
   output logic              done,
   output logic              clk_pulse,
   output logic              data_pulse
);
   localparam int unsigned CELL_W = cnt_width(CELL_CYC);
   localparam int unsigned BIT_W  = cnt_width(WORD_W);
   localparam int unsigned CNT_W  = cnt_width(WORDS + 1);
   localparam logic [CELL_W-1:0] CELL_LAST = CELL_W'(CELL_CYC - 1);
   localparam logic [CELL_W-1:0] CLK_LAST  = CELL_W'(CLK_W - 1);
   localparam logic [CELL_W-1:0] DAT_FIRST = CELL_W'(DAT_OFF);
   localparam logic [CELL_W-1:0] DAT_LAST  = CELL_W'(DAT_OFF + DAT_W - 1);
   localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0]  WORD_CNT  = CNT_W'(WORDS);

   generate
      if (CELL_CYC < 2) begin : g_chk_cell
         $error("sread_serial: CELL_CYC must be at least 2");
      end
      if (CLK_W < 1 || DAT_W < 1) begin : g_chk_width
         $error("sread_serial: pulse widths must be at least 1");
      end
      if (DAT_OFF < CLK_W) begin : g_chk_overlap
         $error("sread_serial: data pulse must start after the clock pulse");
      end
      if (DAT_OFF + DAT_W > CELL_CYC) begin : g_chk_fit
         $error("sread_serial: data pulse must end inside the cell");
      end
   endgenerate

   logic [WORD_W-1:0] shreg;
   logic [CELL_W-1:0] cell_cnt;
   logic [BIT_W-1:0]  bit_cnt;
   logic [CNT_W-1:0]  sent;
   logic              loaded;
   logic              cell_end;
   logic              word_end;

   assign cell_end = (cell_cnt == CELL_LAST);
   assign word_end = loaded && cell_end && (bit_cnt == BIT_LAST);
   assign finish   = word_end && (sent == WORD_CNT);
   assign take     = busy && buf_valid && (sent != WORD_CNT) && (!loaded || word_end);

   assign clk_pulse  = loaded && (cell_cnt <= CLK_LAST);
   assign data_pulse = loaded && shreg[WORD_W-1] &&
                       (cell_cnt >= DAT_FIRST) && (cell_cnt <= DAT_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg    <= '0;
         cell_cnt <= '0;
         bit_cnt  <= '0;
         sent     <= '0;
         loaded   <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= finish;
         if (take) begin
            shreg    <= buf_data;
            loaded   <= 1'b1;
            cell_cnt <= '0;
            bit_cnt  <= '0;
            sent     <= sent + 1'b1;
         end else if (word_end) begin
            loaded   <= 1'b0;
            cell_cnt <= '0;
            bit_cnt  <= '0;
            if (finish) begin
               sent <= '0;
            end
         end else if (loaded) begin
            if (cell_end) begin
               cell_cnt <= '0;
               bit_cnt  <= bit_cnt + 1'b1;
               shreg    <= {shreg[WORD_W-2:0], 1'b0};
            end else begin
               cell_cnt <= cell_cnt + 1'b1;
            end
         end
      end
   end

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(clk_pulse && data_pulse)); // R6

   AST_CELL_CHAIN: assert property (@(posedge clk) disable iff (rst)
      (loaded && cell_end && !word_end) |=> clk_pulse); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (!clk_pulse && !data_pulse)); // R1

endmodule

// File: rtl/sector_read_streamer.sv
module sector_read_streamer #(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned WORDS     = 321,
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned CYL_W     = 8,
   parameter int unsigned HEAD_W    = 1,
   parameter int unsigned SEC_W     = 2,
   parameter int unsigned SLOT_LOG2 = 9,
   parameter int unsigned CELL_CYC  = 8,
   parameter int unsigned CLK_W     = 2,
   parameter int unsigned DAT_OFF   = 4,
   parameter int unsigned DAT_W     = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              xfer_start,
   input  logic [CYL_W-1:0]  cyl_in,
   input  logic [HEAD_W-1:0] head_in,
   input  logic [SEC_W-1:0]  sect_in,
   output logic              busy,
   output logic              done,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [WORD_W-1:0] rd_data,
   output logic              clk_pulse,
   output logic              data_pulse
);
   generate
      if (WORDS > (1 << SLOT_LOG2)) begin : g_chk_slot
         $error("sector_read_streamer: sector does not fit its slot");
      end
      if (WORD_W < 2) begin : g_chk_word
         $error("sector_read_streamer: WORD_W must be at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] base;
   logic              take;
   logic              finish;
   logic              buf_valid;
   logic [WORD_W-1:0] buf_data;

   sread_addr_map #(
      .CYL_W(CYL_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W),
      .SLOT_LOG2(SLOT_LOG2), .ADDR_W(ADDR_W)
   ) i_map (
      .cyl(cyl_in), .head(head_in), .sect(sect_in), .base(base)
   );

   sread_fetch #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)
   ) i_fetch (
      .clk(clk), .rst(rst), .start(xfer_start), .base_in(base),
      .take(take), .finish(finish), .rd_ack(rd_ack), .rd_data(rd_data),
      .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
      .buf_valid(buf_valid), .buf_data(buf_data)
   );

   sread_serial #(
      .WORD_W(WORD_W), .WORDS(WORDS), .CELL_CYC(CELL_CYC),
      .CLK_W(CLK_W), .DAT_OFF(DAT_OFF), .DAT_W(DAT_W)
   ) i_serial (
      .clk(clk), .rst(rst), .busy(busy), .buf_valid(buf_valid),
      .buf_data(buf_data), .take(take), .finish(finish), .done(done),
      .clk_pulse(clk_pulse), .data_pulse(data_pulse)
   );

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy); // R9

   AST_START_QUIET: assert property (@(posedge clk) disable iff (rst)
      (xfer_start && !busy) |=> (busy && !clk_pulse)); // R8

endmodule

// File: tb/test_sector_read_streamer.sv
module test_sector_read_streamer;
   localparam int WORD_W = 16;
   localparam int WORDS  = 321;
   localparam int ADDR_W = 24;
   localparam int CELL   = 4;
   localparam int CLKW   = 1;
   localparam int DOFF   = 2;
   localparam int DW     = 1;

   logic              clk = 1'b0;
   logic              rst;
   logic              xfer_start;
   logic [7:0]        cyl_in;
   logic [0:0]        head_in;
   logic [1:0]        sect_in;
   logic              busy, done, rd_req, rd_ack;
   logic [ADDR_W-1:0] rd_addr;
   logic [WORD_W-1:0] rd_data;
   logic              clk_pulse, data_pulse;

   int n_cmp = 0;
   int n_bad = 0;

   sector_read_streamer #(
      .CELL_CYC(CELL), .CLK_W(CLKW), .DAT_OFF(DOFF), .DAT_W(DW)
   ) i_sector_read_streamer (
      .clk(clk), .rst(rst), .xfer_start(xfer_start), .cyl_in(cyl_in),
      .head_in(head_in), .sect_in(sect_in), .busy(busy), .done(done),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .clk_pulse(clk_pulse), .data_pulse(data_pulse)
   );

   always #2 clk = ~clk;

   function automatic int exp_base(input int c, input int h, input int s);
      return c * 4096 + h * 2048 + s * 512;
   endfunction

   function automatic logic [15:0] mem_word(input int a);
      logic [31:0] v;
      v = a;
      return v[15:0] ^ 16'h5A3C ^ {v[23:16], 8'h00};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // shared run state
   bit chk_en = 0;
   int exp_addr, n_reads, first_addr, last_addr;
   int cur_base, words_rx, nbits, done_cnt;
   bit have_prev;
   logic [15:0] cur_word;
   longint cyc = 0;
   longint last_start;

   // memory responder
   initial begin
      rd_ack = 1'b0;
      rd_data = '0;
      forever begin
         @(negedge clk);
         if (rd_req) begin
            int lat;
            lat = 1 + int'($urandom % 20);
            repeat (lat - 1) @(negedge clk);
            if (chk_en) begin
               check(rd_addr == exp_addr[ADDR_W-1:0], "R3 address order", rd_addr, exp_addr);
               if (n_reads == 0) first_addr = rd_addr;
               last_addr = rd_addr;
               exp_addr++;
               n_reads++;
            end
            rd_ack = 1'b1;
            rd_data = mem_word(rd_addr);
            @(negedge clk);
            rd_ack = 1'b0;
         end
      end
   end

   // pulse monitor
   initial begin
      int off;
      bit prev_clk, prev_done;
      off = 0; prev_clk = 0; prev_done = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (chk_en) begin
            if (clk_pulse && !prev_clk) begin
               if (have_prev)
                  check(cyc - last_start == CELL, "R7 cell spacing", int'(cyc - last_start), CELL);
               have_prev = 1;
               last_start = cyc;
               off = 0;
               check(!data_pulse, "R6 data low at cell start", data_pulse, 0);
            end else begin
               off++;
            end
            if (have_prev && off == CLKW && off < CELL)
               check(!clk_pulse, "R5 clock pulse width", clk_pulse, 0);
            if (have_prev && off == DOFF) begin
               cur_word = {cur_word[14:0], data_pulse};
               nbits++;
               if (nbits == WORD_W) begin
                  check(cur_word == mem_word(cur_base + words_rx), "R10 word value",
                        cur_word, mem_word(cur_base + words_rx));
                  words_rx++;
                  nbits = 0;
               end
            end
            if (done) begin
               done_cnt++;
               check(cyc - last_start == CELL, "R9 done timing", int'(cyc - last_start), CELL);
               check(!busy, "R9 busy low with done", busy, 0);
               check(!prev_done, "R9 done single cycle", prev_done, 0);
            end
         end
         prev_clk = clk_pulse;
         prev_done = done;
      end
   end

   task automatic arm(input int c, input int h, input int s);
      cur_base = exp_base(c, h, s);
      exp_addr = cur_base;
      n_reads = 0; words_rx = 0; nbits = 0; done_cnt = 0;
      have_prev = 0; cur_word = '0;
      chk_en = 1;
   endtask

   task automatic run_sector(input int c, input int h, input int s, input bit poke);
      @(negedge clk);
      arm(c, h, s);
      cyl_in = 8'(c); head_in = 1'(h); sect_in = 2'(s);
      xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
      check(busy, "R8 busy after accepted start", busy, 1);
      if (poke) begin
         repeat (3000) @(negedge clk);
         cyl_in = ~cyl_in; head_in = ~head_in; sect_in = ~sect_in;
         xfer_start = 1'b1;           // R8: must be ignored
         @(negedge clk);
         xfer_start = 1'b0;
         repeat (5000) @(negedge clk);
         xfer_start = 1'b1;
         repeat (3) @(negedge clk);
         xfer_start = 1'b0;
      end
      while (done_cnt == 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk_en = 0;
      check(first_addr == cur_base, "R2 base address", first_addr, cur_base);
      check(n_reads == WORDS, "R3 read count", n_reads, WORDS);
      check(last_addr == cur_base + WORDS - 1, "R3 last address", last_addr, cur_base + WORDS - 1);
      check(words_rx == WORDS, "R10 words sent", words_rx, WORDS);
      check(done_cnt == 1, "R9 done count", done_cnt, 1);
      check(!busy && !rd_req, "R8 idle after sector", {busy, rd_req}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1130));
      rst = 1'b1; xfer_start = 1'b0; cyl_in = '0; head_in = '0; sect_in = '0;
      repeat (4) @(negedge clk);
      check({clk_pulse, data_pulse, rd_req, busy, done} == 5'b0, "R1 reset state",
            {clk_pulse, data_pulse, rd_req, busy, done}, 0);
      rst = 1'b0;

      // R2/R3: directed slot 1/1/1, expected 0x1A00..0x1B40
      run_sector(1, 1, 1, 1'b0);
      check(first_addr == 32'h1A00, "R2 base of 1/1/1", first_addr, 32'h1A00);
      check(last_addr == 32'h1B40, "R3 end of 1/1/1", last_addr, 32'h1B40);
      // R2: zero slot
      run_sector(0, 0, 0, 1'b0);
      // R2: highest slot, R8 with pokes mid sector
      run_sector(255, 1, 3, 1'b1);
      // random slots
      for (int k = 0; k < 2; k++) begin
         run_sector(int'($urandom % 256), int'($urandom % 2), int'($urandom % 4), 1'b0);
      end

      // R1: reset in the middle of a sector
      @(negedge clk);
      cyl_in = 8'd7; head_in = 1'b0; sect_in = 2'd2;
      xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
      repeat (1500) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check({clk_pulse, data_pulse, rd_req, busy, done} == 5'b0, "R1 mid-sector reset",
            {clk_pulse, data_pulse, rd_req, busy, done}, 0);
      begin
         bit quiet;
         quiet = 1;
         repeat (100) begin
            @(negedge clk);
            if (rd_req || clk_pulse || busy) quiet = 0;
         end
         check(quiet, "R1 stays idle after reset", !quiet, 0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule